// File: doc/BRIEF.md
# Carry-Save Redundant-to-Binary Converter

This block turns a number held as a pair of words, a sum word and a carry word whose value is sum + 2·carry, into one plain two's-complement word. It does not use a carry-propagate adder. Instead it feeds the pair back through a chain of carry-save adders whose third operand is tied to zero. The sum word then absorbs the carries step by step, and the block stops as soon as the carry word is empty. A wide NOR over the carry word detects that point. Two carry-save stages sit in the loop, so each clock performs two iterations. The latency depends on the data and grows roughly with the logarithm of the width for typical operands.

A pulse on `start_i` loads the two words. Results come back with a one-cycle `done_o` pulse, and the sign of the result is reported on `neg_o`. All arithmetic wraps at the word width, so negative redundant values convert correctly. A guard counter bounds the number of iterations and flags an error if that bound were ever passed.

Top module: `rb_converter`

## Requirements
- R1: When `done_o` is high, `result_o` equals (`sum_i` + 2·`carry_i`) modulo 2^WIDTH, using the values loaded at the accepted start. Bit WIDTH-1 of `carry_i` does not contribute.
- R2: When `done_o` is high, `neg_o` equals bit WIDTH-1 of `result_o`, the two's-complement sign.
- R3: If the loaded carry word is all zero, `done_o` rises in the first cycle after the start edge, and `result_o` equals `sum_i` unchanged.
- R4: Two carry-save iterations complete per clock. With `sum_i` all ones and `carry_i` = 1, the carry ripples one bit per iteration and needs WIDTH iterations. `done_o` therefore rises WIDTH/2 + 1 cycles after the start edge, which is 17 at WIDTH = 32.
- R5: `done_o` is high for exactly one cycle unless a new start is accepted in that cycle. `result_o` then holds its value until the next accepted start.
- R6: A `start_i` that arrives while a conversion is running and `done_o` is low is ignored: the running conversion's result and timing are unaffected.
- R7: A `start_i` in the same cycle as `done_o` is accepted, and that new conversion proceeds normally.
- R8: The guard counter raises `err_o` only if WIDTH iterations have passed with a non-zero carry word. Because every iteration moves the lowest carry bit up by at least one position, `err_o` stays low for every input.
- R9: After synchronous active-low reset, `done_o`, `err_o` and `neg_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load `sum_i`/`carry_i` and begin a conversion |
| sum_i | input | WIDTH | Sum word of the redundant operand |
| carry_i | input | WIDTH | Carry word, weighted by two |
| result_o | output | WIDTH | Converted two's-complement value |
| neg_o | output | 1 | Sign bit of `result_o` |
| done_o | output | 1 | One-cycle pulse: `result_o` is final |
| err_o | output | 1 | Iteration bound exceeded |

## Verification
Two events can land in the same cycle: a conversion finishing and a new start arriving. The bench waits for `done_o` to be seen and raises `start_i` in that same cycle with fresh operands. It then checks that the first result was correct when it was presented, and that the second conversion completes with its own correct sum and the latency its carry pattern implies. A start raised in the middle of a long ripple is the opposite case: it must not disturb the running conversion.

// File: rtl/cs2b_pkg.sv
// Shared defaults for the redundant-to-binary converter.
// Assumes: nothing beyond standard SystemVerilog.
package cs2b_pkg;
    localparam int unsigned DEF_WIDTH  = 32;
    localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/cs2b_stage.sv
// One carry-save iteration with the third operand tied to zero:
// (s, c) <- CSA(0, s, 2c). The value s + 2c is preserved modulo 2^W.
// Assumes: W >= 2; the carry bit shifted past the MSB is discarded (wrap).
module cs2b_stage #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    logic [W-1:0] dbl;
    logic [W-1:0] zero_op;
    wire unused_msb = c_i[W-1];

    // Full-adder row: operands s_i, 2*c_i and a constant zero.
    always_comb begin
        dbl     = {c_i[W-2:0], 1'b0};
        zero_op = '0;
        s_o     = s_i ^ dbl ^ zero_op;
        c_o     = (s_i & dbl) | (s_i & zero_op) | (dbl & zero_op);
    end

    // Value-preservation check of one iteration.
    always_comb begin
        if (!$isunknown({s_i, c_i})) begin
            // R1
            value_keep_stage_chk: assert ((s_o + {c_o[W-2:0], 1'b0}) == (s_i + {c_i[W-2:0], 1'b0}))
                else $error("carry-save stage changed the represented value");
        end
    end
endmodule

// File: rtl/cs2b_chain.sv
// Chains STAGES carry-save iterations combinationally, giving STAGES
// iterations per clock in the enclosing loop.
// Assumes: STAGES >= 1.
module cs2b_chain #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    logic [W-1:0] s_w [STAGES+1];
    logic [W-1:0] c_w [STAGES+1];

    assign s_w[0] = s_i;
    assign c_w[0] = c_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        cs2b_stage #(.W(W)) u_stage (
            .s_i (s_w[g]),
            .c_i (c_w[g]),
            .s_o (s_w[g+1]),
            .c_o (c_w[g+1])
        );
    end

    assign s_o = s_w[STAGES];
    assign c_o = c_w[STAGES];
endmodule

// File: rtl/cs2b_zero_det.sv
// Wide NOR: reports that every bit of the carry word is zero.
// Assumes: nothing.
module cs2b_zero_det #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic         zero_o
);
    // Reduction NOR over the whole word.
    assign zero_o = ~|vec_i;
endmodule

// File: rtl/rb_converter.sv
// Redundant-to-binary converter. Loads (sum, carry), iterates STAGES
// carry-save steps per clock until the carry word is zero, then pulses done.
// A guard counter bounds the iteration count at WIDTH.
// Assumes: WIDTH even or odd, WIDTH >= 2; synchronous active-low reset.
module rb_converter #(
    parameter int unsigned WIDTH  = cs2b_pkg::DEF_WIDTH,
    parameter int unsigned STAGES = cs2b_pkg::DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             neg_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int unsigned CNT_W = $clog2(WIDTH + STAGES + 1) + 1;
    localparam logic [CNT_W-1:0] ITER_LIMIT = CNT_W'(WIDTH);
    localparam logic [CNT_W-1:0] ITER_STEP  = CNT_W'(STAGES);

    logic [WIDTH-1:0] ss_q, sc_q;
    logic [WIDTH-1:0] ss_nx, sc_nx;
    logic [CNT_W-1:0] iter_q;
    logic             busy_q, err_q;
    logic             carry_zero;
    logic             accept;

    cs2b_chain #(.W(WIDTH), .STAGES(STAGES)) u_chain (
        .s_i (ss_q),
        .c_i (sc_q),
        .s_o (ss_nx),
        .c_o (sc_nx)
    );

    cs2b_zero_det #(.W(WIDTH)) u_zdet (
        .vec_i  (sc_q),
        .zero_o (carry_zero)
    );

    // Completion and acceptance decode.
    assign done_o = busy_q & carry_zero;
    assign accept = start_i & (~busy_q | done_o);

    // Iteration loop: load, step, finish or stop on the guard bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q   <= '0;
            sc_q   <= '0;
            iter_q <= '0;
            busy_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (accept) begin
            ss_q   <= sum_i;
            sc_q   <= carry_i;
            iter_q <= '0;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
        end else if (busy_q) begin
            if (carry_zero) begin
                busy_q <= 1'b0;
            end else if (iter_q >= ITER_LIMIT) begin
                busy_q <= 1'b0;
                err_q  <= 1'b1;
            end else begin
                ss_q   <= ss_nx;
                sc_q   <= sc_nx;
                iter_q <= iter_q + ITER_STEP;
            end
        end
    end

    // Output mapping.
    assign result_o = ss_q;
    assign neg_o    = ss_q[WIDTH-1];
    assign err_o    = err_q;

    // Represented value of the working pair, for the hold check.
    logic [WIDTH-1:0] held_val;
    assign held_val = ss_q + {sc_q[WIDTH-2:0], 1'b0};

    // R7
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (!busy_q || done_o)) |=> busy_q)
        else $error("accepted start did not begin a conversion");

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o)
        else $error("done held longer than one cycle");

    // R8
    no_guard_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o)
        else $error("iteration bound exceeded");

    // R1
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_o && !start_i) |=> (held_val == $past(held_val)))
        else $error("loop changed the represented value");

    // R6
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_o && start_i) |=> ($past(iter_q) + ITER_STEP == iter_q || err_q))
        else $error("start during conversion disturbed the loop");
endmodule

// File: tb/tb_rb_converter.sv
// Directed bench for rb_converter: one task per scenario, each self-checking.
module tb_rb_converter;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] sum_i = '0;
    logic [W-1:0] carry_i = '0;
    logic [W-1:0] result_o;
    logic         neg_o, done_o, err_o;

    int n_checks = 0;
    int n_errors = 0;

    rb_converter #(.WIDTH(W), .STAGES(2)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sum_i    (sum_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .neg_o    (neg_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

    always #10 clk = ~clk;

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(20 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run hung (actual running, expected finished)");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_val(input logic [W-1:0] s, input logic [W-1:0] c);
        return s + (c << 1);
    endfunction

    // Pulse start at a negedge, then wait for done; returns cycles after start edge.
    task automatic convert(input logic [W-1:0] s, input logic [W-1:0] c, output int cycles);
        @(negedge clk);
        sum_i = s; carry_i = c; start_i = 1'b1;
        cycles = 0;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 1;
        while (!done_o && cycles < 64) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic check_done(input string req, input logic [W-1:0] s, input logic [W-1:0] c);
        check({req, " done"}, W'(done_o), W'(1));
        check({req, " result R1"}, result_o, ref_val(s, c));
        check({req, " sign R2"}, W'(neg_o), W'(ref_val(s, c) >> (W-1)));
        check({req, " guard R8"}, W'(err_o), W'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 done", W'(done_o), W'(0));
        check("R9 err", W'(err_o), W'(0));
        check("R9 neg", W'(neg_o), W'(0));
        check("R9 result", result_o, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_zero_carry();
        int cyc;
        convert(32'h8000_1234, '0, cyc);
        check("R3 latency", W'(cyc), W'(1));
        check_done("R3", 32'h8000_1234, '0);
        check("R3 passthrough", result_o, 32'h8000_1234);
    endtask

    task automatic t_worst();
        int cyc;
        convert('1, 32'h1, cyc);
        check("R4 latency", W'(cyc), W'(W/2 + 1));
        check_done("R4", '1, 32'h1);
    endtask

    task automatic t_hold();
        logic [W-1:0] r;
        int cyc;
        convert(32'h0F0F_0F0F, 32'h0101_0101, cyc);
        check_done("R5", 32'h0F0F_0F0F, 32'h0101_0101);
        r = result_o;
        @(negedge clk);
        check("R5 done pulse", W'(done_o), W'(0));
        repeat (3) @(negedge clk);
        check("R5 result held", result_o, r);
    endtask

    task automatic t_negative();
        int cyc;
        convert(32'hFFFF_FF00, 32'hFFFF_FFC0, cyc);
        check_done("R2 negative", 32'hFFFF_FF00, 32'hFFFF_FFC0);
        check("R2 neg set", W'(neg_o), W'(1));
        convert(32'h8000_0000, 32'h4000_0000, cyc);
        check_done("R1 wrap", 32'h8000_0000, 32'h4000_0000);
        check("R1 wrap zero", result_o, '0);
    endtask

    task automatic t_random();
        int cyc;
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] s, c;
            s = $urandom();
            c = $urandom();
            convert(s, c, cyc);
            check_done("R1 random", s, c);
        end
    endtask

    task automatic t_ignore_start();
        int cyc;
        @(negedge clk);
        sum_i = '1; carry_i = 32'h1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        repeat (3) begin @(negedge clk); cyc++; end
        sum_i = 32'h1111_1111; carry_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; cyc++;
        while (!done_o && cyc < 64) begin @(negedge clk); cyc++; end
        check("R6 latency unchanged", W'(cyc), W'(W/2 + 1));
        check_done("R6", '1, 32'h1);
    endtask

    task automatic t_back_to_back();
        int cyc;
        convert(32'h7FFF_FFFF, 32'h0000_0001, cyc);
        check_done("R7 first", 32'h7FFF_FFFF, 32'h0000_0001);
        sum_i = 32'h0000_00FF; carry_i = 32'h0000_0001; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        check("R7 accepted, not done yet", W'(done_o), W'(0));
        while (!done_o && cyc < 64) begin @(negedge clk); cyc++; end
        check_done("R7 second", 32'h0000_00FF, 32'h0000_0001);
        check("R7 second latency", W'(cyc), W'(5));
    endtask

    initial begin
        t_reset();
        t_zero_carry();
        t_worst();
        t_hold();
        t_negative();
        t_random();
        t_ignore_start();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule